// File: doc/BRIEF.md
# Serial Video Bit-Stream Word Recovery

This block sits behind the clock and data recovery stage of a serial digital video receiver. It takes one recovered bit per bit clock and rebuilds 10-bit parallel video words. The bits pass through three stages in a fixed order. The first turns the NRZI line code back into plain NRZ. The second undoes the self-synchronising x^9 + x^4 + 1 scrambler. The third watches for a timing reference sequence and uses it to fix where each word starts. As the words leave the block, the two low bits of every timing reference character can be forced to zero.

Each stage has its own enable bit in an 8-bit control register inside the block, and each stage can be turned off independently. The register comes out of reset with every stage on. A write port loads a new value into the register. The parallel word is qualified by a single-cycle strobe. A flag reports that the stream has been aligned to a timing reference.

Top module: `svd_rx_top`

## Requirements
- R1: After reset the control register holds 36h, `word_o` is 000h, `word_vld_o` is 0 and `sync_det_o` is 0. With no write, the block fully decodes a scrambled, NRZI-coded stream.
- R2: Bit 1 of the control register enables NRZI decoding, where each decoded bit is the XOR of the current and previous line bits. When bit 1 is 0, line bits pass through unchanged.
- R3: Bit 2 enables descrambling, where each output bit is the XOR of the current input bit with the input bits 4 and 9 bit times earlier. When bit 2 is 0, bits pass through unchanged.
- R4: Bit 4 enables detection of the three-word pattern 3FFh, 000h, 000h at any bit offset. On a match, the word boundary moves so that these three words, and every word after them, come out aligned.
- R5: `sync_det_o` goes to 1 on a detected pattern and holds until reset. While bit 4 is 0 it reads 0, no pattern is recognised, and the existing word boundary is kept.
- R6: When bit 5 is 1, the two least significant bits of each of the three detected timing reference words are forced to 0, so 3FFh comes out as 3FCh. When bit 5 is 0, the words come out unmodified.
- R7: Bits are assembled LSB-first: the earliest bit of a word lands in bit 0. `word_vld_o` is a one-cycle pulse, and consecutive pulses on an aligned stream are exactly 10 bit clocks apart.
- R8: A cycle with `ctrl_we_i` high loads `ctrl_wdata_i` on that clock edge. Bits 0, 3, 6 and 7 of the register have no effect on the output words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sdi_i | input | 1 | Serial line bit, one per clock |
| ctrl_we_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 8 | Control register write data |
| word_o | output | 10 | Recovered parallel word |
| word_vld_o | output | 1 | One-cycle strobe marking a new word |
| sync_det_o | output | 1 | Stream aligned to a timing reference |

## Verification
The bench encodes known word tables with every combination of line code and scrambler settings. It places the timing reference at several bit offsets and checks that the three reference words and the payload after them come out in order and 10 clocks apart. A framer that ignored the match, or realigned one bit off, would never produce the 3FCh, 000h, 000h run. A stage whose bypass was miswired would scramble every payload word.

A mid-stream write turns detection off, and a reference is then sent shifted by three bits. A design that kept detecting would raise the flag or emit a 3FFh/3FCh word, and it would break the 10-clock spacing. A case with clipping off expects 3FFh, which catches a design that always clips. A case that writes FFh catches unused bits leaking into the datapath.

// File: rtl/svd_pkg.sv
package svd_pkg;

  // Control register layout
  localparam int unsigned CTRL_W      = 8;
  localparam logic [7:0]  CTRL_RST    = 8'h36;
  localparam int unsigned BIT_NRZI_EN = 1;
  localparam int unsigned BIT_DSCR_EN = 2;
  localparam int unsigned BIT_SYNC_EN = 4;
  localparam int unsigned BIT_CLIP_EN = 5;

  // Decoded stage enables
  typedef struct packed {
    logic clip_en;
    logic sync_en;
    logic dscr_en;
    logic nrzi_en;
  } svd_cfg_t;

endpackage

// File: rtl/svd_ctrl_reg.sv
module svd_ctrl_reg
  import svd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [CTRL_W-1:0] wdata_i,
  output svd_cfg_t          cfg_o
);

  logic [CTRL_W-1:0] reg_q;
  logic [CTRL_W-1:0] reg_d;

  always_comb begin
    reg_d = reg_q;
    if (we_i) begin
      reg_d = wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_q <= CTRL_RST;
    end else begin
      reg_q <= reg_d;
    end
  end

  always_comb begin
    cfg_o.nrzi_en = reg_q[BIT_NRZI_EN];
    cfg_o.dscr_en = reg_q[BIT_DSCR_EN];
    cfg_o.sync_en = reg_q[BIT_SYNC_EN];
    cfg_o.clip_en = reg_q[BIT_CLIP_EN];
  end

  // R8: the register only changes on a write cycle
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !we_i |=> $stable(reg_q));

endmodule

// File: rtl/svd_nrzi_dec.sv
module svd_nrzi_dec (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic bit_i,
  output logic bit_o
);

  logic prev_q;
  logic out_q;
  logic out_d;

  always_comb begin
    if (en_i) begin
      out_d = bit_i ^ prev_q;
    end else begin
      out_d = bit_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      out_q  <= 1'b0;
    end else begin
      prev_q <= bit_i;
      out_q  <= out_d;
    end
  end

  assign bit_o = out_q;

  // R2: bypass forwards the line bit with one register of delay
  p_bypass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (bit_o == $past(bit_i)));

endmodule

// File: rtl/svd_descram.sv
module svd_descram #(
  parameter int unsigned TAP_A = 4,
  parameter int unsigned TAP_B = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic bit_i,
  output logic bit_o
);

  localparam int unsigned SH_W = TAP_B;

  logic [SH_W-1:0] sh_q;
  logic [SH_W-1:0] sh_d;
  logic            out_q;
  logic            out_d;
  logic            fb;

  always_comb begin
    sh_d = {sh_q[SH_W-2:0], bit_i};
    fb   = sh_q[TAP_A-1] ^ sh_q[TAP_B-1];
    if (en_i) begin
      out_d = bit_i ^ fb;
    end else begin
      out_d = bit_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      out_q <= 1'b0;
    end else begin
      sh_q  <= sh_d;
      out_q <= out_d;
    end
  end

  assign bit_o = out_q;

  // R3: bypass forwards the input bit with one register of delay
  p_bypass_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (bit_o == $past(bit_i)));

endmodule

// File: rtl/svd_framer.sv
module svd_framer #(
  parameter int unsigned WORD_W  = 10,
  parameter int unsigned TRS_LEN = 3,
  parameter int unsigned CLIP_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_i,
  input  logic              sync_en_i,
  input  logic              clip_en_i,
  output logic [WORD_W-1:0] word_o,
  output logic              word_vld_o,
  output logic              sync_det_o
);

  localparam int unsigned HIST_W = (TRS_LEN + 1) * WORD_W;
  localparam int unsigned CNT_W  = $clog2(WORD_W);
  localparam int unsigned TW     = $clog2(TRS_LEN + 1);
  localparam logic [WORD_W-1:0] ONES = {WORD_W{1'b1}};

  logic [HIST_W-1:0] hist_q, hist_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [TW-1:0]     trs_q, trs_d;
  logic [WORD_W-1:0] word_q, word_d;
  logic              vld_q, vld_d;
  logic              sync_q, sync_d;
  logic              trs_hit;
  logic              wrap;

  // Newest bit enters at the top, so the low slice holds the oldest word.
  always_comb begin
    hist_d  = {bit_i, hist_q[HIST_W-1:1]};
    trs_hit = sync_en_i
            && (hist_q[2*WORD_W-1:WORD_W] == ONES)
            && (hist_q[HIST_W-1:2*WORD_W] == '0);
    wrap    = (cnt_q == CNT_W'(WORD_W - 1));

    if (trs_hit || wrap) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + CNT_W'(1);
    end

    word_d = word_q;
    vld_d  = 1'b0;
    trs_d  = trs_q;
    if (wrap) begin
      vld_d  = 1'b1;
      word_d = hist_q[WORD_W-1:0];
      if (trs_q != '0) begin
        if (clip_en_i) begin
          word_d[CLIP_W-1:0] = '0;
        end
        trs_d = trs_q - TW'(1);
      end
    end
    if (trs_hit) begin
      trs_d = TW'(TRS_LEN);
    end

    sync_d = sync_en_i && (sync_q || trs_hit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
      cnt_q  <= '0;
      trs_q  <= '0;
      word_q <= '0;
      vld_q  <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      hist_q <= hist_d;
      cnt_q  <= cnt_d;
      trs_q  <= trs_d;
      word_q <= word_d;
      vld_q  <= vld_d;
      sync_q <= sync_d;
    end
  end

  assign word_o     = word_q;
  assign word_vld_o = vld_q;
  assign sync_det_o = sync_q;

  // R7: the strobe never lasts two cycles
  p_strobe_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld_o |=> !word_vld_o);

  // R5: detection switched off clears the flag one cycle later
  p_sync_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_en_i |=> !sync_det_o);

  // R4: the flag only rises while detection is enabled
  p_sync_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_det_o) |-> $past(sync_en_i));

  // R6: a clipped word never reaches the output with low bits set
  p_clip_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && clip_en_i && (trs_q != '0)) |=> (word_o[CLIP_W-1:0] == '0));

endmodule

// File: rtl/svd_rx_top.sv
module svd_rx_top
  import svd_pkg::*;
#(
  parameter int unsigned WORD_W = 10,
  parameter int unsigned TAP_A  = 4,
  parameter int unsigned TAP_B  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sdi_i,
  input  logic              ctrl_we_i,
  input  logic [CTRL_W-1:0] ctrl_wdata_i,
  output logic [WORD_W-1:0] word_o,
  output logic              word_vld_o,
  output logic              sync_det_o
);

  svd_cfg_t cfg;
  logic     nrz_bit;
  logic     plain_bit;

  svd_ctrl_reg u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (ctrl_we_i),
    .wdata_i (ctrl_wdata_i),
    .cfg_o   (cfg)
  );

  svd_nrzi_dec u_nrzi (
    .clk   (clk),
    .rst_n (rst_n),
    .en_i  (cfg.nrzi_en),
    .bit_i (sdi_i),
    .bit_o (nrz_bit)
  );

  svd_descram #(
    .TAP_A (TAP_A),
    .TAP_B (TAP_B)
  ) u_dscr (
    .clk   (clk),
    .rst_n (rst_n),
    .en_i  (cfg.dscr_en),
    .bit_i (nrz_bit),
    .bit_o (plain_bit)
  );

  svd_framer #(
    .WORD_W  (WORD_W),
    .TRS_LEN (3),
    .CLIP_W  (2)
  ) u_frm (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_i      (plain_bit),
    .sync_en_i  (cfg.sync_en),
    .clip_en_i  (cfg.clip_en),
    .word_o     (word_o),
    .word_vld_o (word_vld_o),
    .sync_det_o (sync_det_o)
  );

endmodule

// File: tb/svd_rx_top_tb_top.sv
`timescale 1ns/1ps
module svd_rx_top_tb_top;

  localparam int W     = 10;
  localparam int NVEC  = 16;
  localparam int TRS_I = 4;
  localparam int NSCN  = 6;
  localparam int MONSZ = 1024;

  // {stimulus word, expected word with clipping on}
  localparam logic [19:0] VEC [NVEC] = '{
    {10'h155, 10'h155}, {10'h0AA, 10'h0AA}, {10'h2C3, 10'h2C3}, {10'h0AA, 10'h0AA},
    {10'h3FF, 10'h3FC}, {10'h000, 10'h000}, {10'h000, 10'h000}, {10'h274, 10'h274},
    {10'h1E5, 10'h1E5}, {10'h040, 10'h040}, {10'h123, 10'h123}, {10'h2DB, 10'h2DB},
    {10'h0F0, 10'h0F0}, {10'h30C, 10'h30C}, {10'h1A5, 10'h1A5}, {10'h05A, 10'h05A}
  };

  // {ctrl, nrzi on, scramble on, clip on, bit offset[3:0]}
  localparam logic [14:0] SCN [NSCN] = '{
    {8'h36, 1'b1, 1'b1, 1'b1, 4'd7},
    {8'h34, 1'b0, 1'b1, 1'b1, 4'd3},
    {8'h32, 1'b1, 1'b0, 1'b1, 4'd0},
    {8'h30, 1'b0, 1'b0, 1'b1, 4'd5},
    {8'h16, 1'b1, 1'b1, 1'b0, 4'd9},
    {8'hFF, 1'b1, 1'b1, 1'b1, 4'd2}
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic       sdi;
  logic       ctrl_we;
  logic [7:0] ctrl_wdata;
  logic [9:0] word;
  logic       word_vld;
  logic       sync_det;

  int checks = 0;
  int errors = 0;

  logic [9:0] mon_w [MONSZ];
  int         mon_t [MONSZ];
  int         mon_n = 0;
  int         cyc = 0;

  logic [8:0] enc_sh;
  logic       enc_prev;
  logic       pend_we;
  logic [7:0] pend_data;

  always #2 clk = ~clk;

  svd_rx_top dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .sdi_i        (sdi),
    .ctrl_we_i    (ctrl_we),
    .ctrl_wdata_i (ctrl_wdata),
    .word_o       (word),
    .word_vld_o   (word_vld),
    .sync_det_o   (sync_det)
  );

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (word_vld && mon_n < MONSZ) begin
      mon_w[mon_n] = word;
      mon_t[mon_n] = cyc;
      mon_n = mon_n + 1;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors = errors + 1;
    $display("FAIL watchdog: run did not finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; sdi = 1'b0; ctrl_we = 1'b0; ctrl_wdata = 8'h00; pend_we = 1'b0;
    enc_sh = '0; enc_prev = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  // Write during idle: a zero line is consistent with every encoder setting.
  task automatic idle_write(input logic [7:0] v);
    @(negedge clk);
    ctrl_we = 1'b1; ctrl_wdata = v;
    @(negedge clk);
    ctrl_we = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    sdi = b;
    ctrl_we = pend_we;
    ctrl_wdata = pend_data;
    pend_we = 1'b0;
  endtask

  task automatic enc_bit(input logic d, input logic nrzi_on, input logic scr_on);
    logic s;
    s = scr_on ? (d ^ enc_sh[3] ^ enc_sh[8]) : d;
    enc_sh = {enc_sh[7:0], s};
    if (nrzi_on) begin
      enc_prev = enc_prev ^ s;
      send_bit(enc_prev);
    end else begin
      send_bit(s);
    end
  endtask

  task automatic send_stream(input int off, input logic nz, input logic sc);
    for (int i = 0; i < off; i++) enc_bit(i[0], nz, sc);
    for (int k = 0; k < NVEC; k++) begin
      for (int b = 0; b < W; b++) enc_bit(VEC[k][10+b], nz, sc);
    end
    for (int i = 0; i < 60; i++) enc_bit(1'b0, nz, sc);
  endtask

  // R4, R6, R7: locate aligned reference run, then compare the rest in order
  task automatic check_seq(input int start, input logic clip_on, input string tag);
    int found;
    logic [9:0] first;
    found = -1;
    first = clip_on ? 10'h3FC : 10'h3FF;
    for (int i = start; i + 2 < mon_n; i++) begin
      if (found < 0 && mon_w[i] == first && mon_w[i+1] == 10'h000 && mon_w[i+2] == 10'h000)
        found = i;
    end
    chk(found >= 0, {tag, " R4 aligned reference run"}, found, start);
    if (found >= 0) begin
      for (int j = 0; j < NVEC - TRS_I; j++) begin
        logic [9:0] e;
        e = clip_on ? VEC[TRS_I+j][9:0] : VEC[TRS_I+j][19:10];
        if (found + j < mon_n) begin
          chk(mon_w[found+j] == e, {tag, " R6/R7 word"}, mon_w[found+j], e);
          if (j > 0)
            chk(mon_t[found+j] - mon_t[found+j-1] == W, {tag, " R7 strobe spacing"},
                mon_t[found+j] - mon_t[found+j-1], W);
        end else begin
          chk(1'b0, {tag, " R7 word missing"}, found + j, mon_n);
        end
      end
    end
  endtask

  function automatic string scn_tag(input int s);
    case (s)
      0: return "scn0 R2/R3 full decode";
      1: return "scn1 R2 nrzi bypass";
      2: return "scn2 R3 descramble bypass";
      3: return "scn3 R2/R3 both bypassed";
      4: return "scn4 R6 clip off";
      default: return "scn5 R8 unused bits set";
    endcase
  endfunction

  initial begin
    int start;
    int bad;
    rst_n = 1'b0; sdi = 1'b0; ctrl_we = 1'b0; ctrl_wdata = 8'h00;
    pend_we = 1'b0; pend_data = 8'h00; enc_sh = '0; enc_prev = 1'b0;

    // R1: reset state
    do_reset();
    chk(word == 10'h000, "R1 reset word", word, 0);
    chk(word_vld == 1'b0, "R1 reset strobe", word_vld, 0);
    chk(sync_det == 1'b0, "R1 reset sync flag", sync_det, 0);

    // Table-driven scenarios
    for (int s = 0; s < NSCN; s++) begin
      do_reset();
      idle_write(SCN[s][14:7]);
      start = mon_n;
      send_stream(int'(SCN[s][3:0]), SCN[s][6], SCN[s][5]);
      chk(sync_det == 1'b1, {scn_tag(s), " R5 sync flag"}, sync_det, 1);
      check_seq(start, SCN[s][4], scn_tag(s));
    end

    // R1: no write, reset value must decode; then R5: detection off mid-stream
    do_reset();
    start = mon_n;
    send_stream(4, 1'b1, 1'b1);
    chk(sync_det == 1'b1, "R1/R5 sync flag with reset config", sync_det, 1);
    check_seq(start, 1'b1, "R1 reset config decode");

    pend_we = 1'b1; pend_data = 8'h26;
    start = mon_n;
    send_stream(3, 1'b1, 1'b1);
    chk(sync_det == 1'b0, "R5 flag cleared with detection off", sync_det, 0);
    bad = 0;
    for (int i = start; i < mon_n; i++)
      if (mon_w[i] == 10'h3FF || mon_w[i] == 10'h3FC) bad++;
    chk(bad == 0, "R5 no realignment on shifted reference", bad, 0);
    bad = 0;
    for (int i = start + 1; i < mon_n; i++)
      if (mon_t[i] - mon_t[i-1] != W) bad++;
    chk(bad == 0, "R5/R7 boundary kept, spacing steady", bad, 0);
    chk(mon_n - start > 15, "R7 words still emitted", mon_n - start, 16);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule